// File: doc/BRIEF.md
# Exclusive Access Monitor

This block gives a single core the reservation tracking that a load-reserve / store-conditional pair needs. When the core issues a load-exclusive, the monitor stores the granule of the accessed address and arms a reservation. When the core later issues a store-exclusive, the monitor decides in the same cycle whether the store may reach memory. It asserts a commit enable only if the reservation is still armed and covers the store's granule. It also returns a one-bit status: 0 for success, 1 for failure.

A snoop port reports writes made by other agents. A snooped write that falls in the reserved granule disarms the reservation. Every store-exclusive disarms it as well, whatever its outcome. A failed store never raises the commit enable, so the memory side leaves its contents untouched. Addresses are compared at granule width. Bits below the granule size, 64 bytes by default, take no part in any comparison.

Top module: `xmon_top`

## Requirements
- R1: After reset no reservation exists. A store-exclusive issued before any load-exclusive gives commit = 0 and status = 1.
- R2: A store-exclusive to the granule of the most recent load-exclusive, with no disarming event in between, gives commit = 1 and status = 0 in the cycle of the request.
- R3: A store-exclusive to a granule other than the reserved one gives commit = 0 and status = 1.
- R4: Granule matching ignores address bits [GRAN_LOG2-1:0] (bits [5:0] by default). This applies to store-exclusive addresses and to snoop addresses alike.
- R5: A snooped write to the reserved granule, in a cycle after the load-exclusive and before the store-exclusive, makes that store-exclusive fail.
- R6: A snooped write to any other granule leaves the reservation armed.
- R7: Every store-exclusive disarms the reservation, whether it succeeds or fails. The next store-exclusive fails unless a new load-exclusive comes first.
- R8: The commit enable is high only in a cycle with a store-exclusive request whose status is 0. A failed store never raises it.
- R9: The status-valid output equals the store-exclusive request in each cycle. With no request, both commit and status-valid are 0.
- R10: A new load-exclusive replaces the reserved granule. A store-exclusive to the granule of an earlier load-exclusive then fails.
- R11: With KILL_SAME_CYCLE = 1 (the default), a snooped write to the reserved granule in the same cycle as a store-exclusive makes that store fail.
- R12: When a load-exclusive and a store-exclusive arrive in the same cycle, the store is judged against the reservation held before that cycle. The load's granule is reserved afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lx_valid | input | 1 | Load-exclusive request |
| lx_addr | input | ADDR_W | Load-exclusive byte address |
| sx_valid | input | 1 | Store-exclusive request |
| sx_addr | input | ADDR_W | Store-exclusive byte address |
| snp_valid | input | 1 | Write observed from another agent |
| snp_addr | input | ADDR_W | Byte address of the observed write |
| sx_commit | output | 1 | Store may be written to memory |
| sx_resp_valid | output | 1 | Status output is meaningful this cycle |
| sx_status | output | 1 | 0 = store succeeded, 1 = store failed |

## Verification
The bound checker tests several rules on every cycle:
- a commit never appears without a store request, and never with a failing status;
- status-valid follows the request;
- a store before any load-exclusive fails;
- a store right after another store, or right after a conflicting snoop, never commits;
- a store to a granule other than the last reserved one never commits;
- a same-cycle conflicting snoop blocks the store.

Only the directed scenarios show the positive outcomes: that a matching store does succeed, that a different byte offset inside the granule still matches, that a snoop to a neighbouring granule has no effect, and that a load-exclusive issued alongside a store leaves a usable reservation.

// File: rtl/xmon_pkg.sv
package xmon_pkg;
   typedef enum logic {
      XM_PASS = 1'b0,
      XM_FAIL = 1'b1
   } xm_status_e;
endpackage

// File: rtl/xmon_gran_cmp.sv
module xmon_gran_cmp #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 6
) (
   input  logic [ADDR_W-1:0]         addr,
   input  logic [ADDR_W-GRAN_LOG2-1:0] tag,
   output logic                      hit
);
   localparam int TAG_W = ADDR_W - GRAN_LOG2;

   // Only the bits above the granule offset take part in the compare.
   logic [TAG_W-1:0] addr_tag;
   assign addr_tag = addr[ADDR_W-1:GRAN_LOG2];
   assign hit      = (addr_tag == tag);
endmodule

// File: rtl/xmon_resv.sv
module xmon_resv #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 6
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        arm,
   input  logic [ADDR_W-1:0]           arm_addr,
   input  logic                        disarm,
   output logic                        armed,
   output logic [ADDR_W-GRAN_LOG2-1:0] tag
);
   localparam int TAG_W = ADDR_W - GRAN_LOG2;

   // Arm wins over disarm: a load-exclusive in the same cycle as a
   // store-exclusive or snoop leaves the new reservation in place.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         tag   <= '0;
      end else if (arm) begin
         armed <= 1'b1;
         tag   <= arm_addr[ADDR_W-1:GRAN_LOG2];
      end else if (disarm) begin
         armed <= 1'b0;
      end
   end
endmodule

// File: rtl/xmon_judge.sv
module xmon_judge #(
   parameter bit KILL_SAME_CYCLE = 1'b1
) (
   input  logic sx_valid,
   input  logic armed,
   input  logic sx_hit,
   input  logic snp_conflict,
   output logic commit,
   output logic resp_valid,
   output xmon_pkg::xm_status_e status
);
   logic blocked;

   generate
      if (KILL_SAME_CYCLE) begin : g_kill
         assign blocked = snp_conflict;
      end else begin : g_nokill
         assign blocked = 1'b0;
      end
   endgenerate

   logic pass;
   assign pass       = armed & sx_hit & ~blocked;
   assign commit     = sx_valid & pass;
   assign resp_valid = sx_valid;
   assign status     = (sx_valid & ~pass) ? xmon_pkg::XM_FAIL : xmon_pkg::XM_PASS;
endmodule

// File: rtl/xmon_top.sv
module xmon_top #(
   parameter int ADDR_W          = 32,
   parameter int GRAN_LOG2       = 6,
   parameter bit KILL_SAME_CYCLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lx_valid,
   input  logic [ADDR_W-1:0] lx_addr,
   input  logic              sx_valid,
   input  logic [ADDR_W-1:0] sx_addr,
   input  logic              snp_valid,
   input  logic [ADDR_W-1:0] snp_addr,
   output logic              sx_commit,
   output logic              sx_resp_valid,
   output logic              sx_status
);
   localparam int TAG_W = ADDR_W - GRAN_LOG2;

   initial begin
      if (GRAN_LOG2 < 0 || GRAN_LOG2 >= ADDR_W)
         $error("xmon_top: GRAN_LOG2 must lie in [0, ADDR_W-1]");
      if (ADDR_W < 2)
         $error("xmon_top: ADDR_W too small");
   end

   logic             armed;
   logic [TAG_W-1:0] tag;
   logic             sx_hit;
   logic             snp_hit;
   logic             snp_conflict;
   logic             disarm;
   xmon_pkg::xm_status_e status_e;

   xmon_gran_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp_sx (
      .addr(sx_addr), .tag(tag), .hit(sx_hit)
   );

   xmon_gran_cmp #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_cmp_snp (
      .addr(snp_addr), .tag(tag), .hit(snp_hit)
   );

   assign snp_conflict = snp_valid & armed & snp_hit;
   assign disarm       = sx_valid | snp_conflict;

   xmon_resv #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_resv (
      .clk(clk), .rst_n(rst_n),
      .arm(lx_valid), .arm_addr(lx_addr),
      .disarm(disarm),
      .armed(armed), .tag(tag)
   );

   xmon_judge #(.KILL_SAME_CYCLE(KILL_SAME_CYCLE)) u_judge (
      .sx_valid(sx_valid), .armed(armed), .sx_hit(sx_hit),
      .snp_conflict(snp_conflict),
      .commit(sx_commit), .resp_valid(sx_resp_valid), .status(status_e)
   );

   assign sx_status = status_e;
endmodule

// File: rtl/xmon_checker.sv
module xmon_checker #(
   parameter int ADDR_W          = 32,
   parameter int GRAN_LOG2       = 6,
   parameter bit KILL_SAME_CYCLE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lx_valid,
   input logic [ADDR_W-1:0] lx_addr,
   input logic              sx_valid,
   input logic [ADDR_W-1:0] sx_addr,
   input logic              snp_valid,
   input logic [ADDR_W-1:0] snp_addr,
   input logic              sx_commit,
   input logic              sx_resp_valid,
   input logic              sx_status
);
   localparam int TAG_W = ADDR_W - GRAN_LOG2;

   logic             seen_lx;
   logic [TAG_W-1:0] last_tag;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_lx  <= 1'b0;
         last_tag <= '0;
      end else if (lx_valid) begin
         seen_lx  <= 1'b1;
         last_tag <= lx_addr[ADDR_W-1:GRAN_LOG2];
      end
   end

   // R8
   a_r8_commit_needs_pass: assert property (@(posedge clk) disable iff (!rst_n)
      sx_commit |-> (sx_valid && !sx_status));

   // R9
   a_r9_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      sx_resp_valid == sx_valid);

   // R1
   a_r1_no_lx_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && !seen_lx) |-> (!sx_commit && sx_status));

   // R7
   a_r7_back_to_back_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && !lx_valid) |=> !sx_commit);

   // R5
   a_r5_snoop_kills: assert property (@(posedge clk) disable iff (!rst_n)
      (snp_valid && !lx_valid && seen_lx && snp_addr[ADDR_W-1:GRAN_LOG2] == last_tag)
      |=> !sx_commit);

   // R3, R10
   a_r3_wrong_granule_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && seen_lx && sx_addr[ADDR_W-1:GRAN_LOG2] != last_tag) |-> !sx_commit);

   // R11
   generate
      if (KILL_SAME_CYCLE) begin : g_kill_chk
         a_r11_same_cycle_snoop: assert property (@(posedge clk) disable iff (!rst_n)
            (sx_valid && snp_valid &&
             snp_addr[ADDR_W-1:GRAN_LOG2] == sx_addr[ADDR_W-1:GRAN_LOG2]) |-> !sx_commit);
      end
   endgenerate
endmodule

bind xmon_top xmon_checker #(
   .ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2), .KILL_SAME_CYCLE(KILL_SAME_CYCLE)
) u_chk (
   .clk(clk), .rst_n(rst_n),
   .lx_valid(lx_valid), .lx_addr(lx_addr),
   .sx_valid(sx_valid), .sx_addr(sx_addr),
   .snp_valid(snp_valid), .snp_addr(snp_addr),
   .sx_commit(sx_commit), .sx_resp_valid(sx_resp_valid), .sx_status(sx_status)
);

// File: tb/tb_xmon_top.sv
module tb_xmon_top;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          lx_valid = 1'b0;
   logic [AW-1:0] lx_addr = '0;
   logic          sx_valid = 1'b0;
   logic [AW-1:0] sx_addr = '0;
   logic          snp_valid = 1'b0;
   logic [AW-1:0] snp_addr = '0;
   logic          sx_commit, sx_resp_valid, sx_status;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   xmon_top dut (
      .clk(clk), .rst_n(rst_n),
      .lx_valid(lx_valid), .lx_addr(lx_addr),
      .sx_valid(sx_valid), .sx_addr(sx_addr),
      .snp_valid(snp_valid), .snp_addr(snp_addr),
      .sx_commit(sx_commit), .sx_resp_valid(sx_resp_valid), .sx_status(sx_status)
   );

   task automatic check(string req, logic [1:0] act, logic [1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: {commit,status} actual=%b expected=%b", req, act, exp);
      end
   endtask

   // One cycle: drive after the falling edge, sample mid-low-phase, then the rising edge.
   task automatic cyc(bit lv, logic [AW-1:0] la, bit sv, logic [AW-1:0] sa,
                      bit nv, logic [AW-1:0] na, output logic [1:0] res);
      @(negedge clk);
      lx_valid = lv; lx_addr = la;
      sx_valid = sv; sx_addr = sa;
      snp_valid = nv; snp_addr = na;
      #1;
      res = {sx_commit, sx_status};
      @(posedge clk);
      #1;
      lx_valid = 1'b0; sx_valid = 1'b0; snp_valid = 1'b0;
   endtask

   task automatic ld(logic [AW-1:0] a);
      logic [1:0] r;
      cyc(1, a, 0, '0, 0, '0, r);
   endtask

   task automatic snoop(logic [AW-1:0] a);
      logic [1:0] r;
      cyc(0, '0, 0, '0, 1, a, r);
   endtask

   task automatic st(string req, logic [AW-1:0] a, bit expect_ok);
      logic [1:0] r;
      cyc(0, '0, 1, a, 0, '0, r);
      check(req, r, expect_ok ? 2'b10 : 2'b01);
   endtask

   task automatic t_reset();
      logic [1:0] r;
      cyc(0, '0, 0, '0, 0, '0, r);
      check("R9 idle", {sx_commit, sx_resp_valid}, 2'b00);
      n_checks++;
      if (sx_resp_valid !== 1'b0) begin n_fail++; $display("FAIL R9: resp_valid=%b expected=0", sx_resp_valid); end
      st("R1 store without load", 32'h0000_1000, 0);
   endtask

   task automatic t_basic();
      ld(32'h0000_1000);
      st("R2 matching store", 32'h0000_1000, 1);
      st("R7 second store after success", 32'h0000_1000, 0);
   endtask

   task automatic t_mismatch();
      ld(32'h0000_2000);
      st("R3 other granule", 32'h0000_3000, 0);
      st("R7 store after failed store", 32'h0000_2000, 0);
   endtask

   task automatic t_granule();
      ld(32'h0000_4000);
      st("R4 offset inside granule", 32'h0000_403C, 1);
      ld(32'h0000_4000);
      snoop(32'h0000_4020);
      st("R4 R5 snoop inside granule", 32'h0000_4000, 0);
   endtask

   task automatic t_snoop_other();
      ld(32'h0000_5000);
      snoop(32'h0000_5040);
      snoop(32'h0000_4FC0);
      st("R6 snoop other granule", 32'h0000_5000, 1);
   endtask

   task automatic t_replace();
      ld(32'h0000_6000);
      ld(32'h0000_7000);
      st("R10 older granule", 32'h0000_6000, 0);
      ld(32'h0000_6000);
      ld(32'h0000_7000);
      st("R10 newer granule", 32'h0000_7000, 1);
   endtask

   task automatic t_same_cycle_snoop();
      logic [1:0] r;
      ld(32'h0000_8000);
      cyc(0, '0, 1, 32'h0000_8000, 1, 32'h0000_8010, r);
      check("R11 R8 same-cycle snoop", r, 2'b01);
   endtask

   task automatic t_ld_st_same();
      logic [1:0] r;
      ld(32'h0000_9000);
      cyc(1, 32'h0000_A000, 1, 32'h0000_9000, 0, '0, r);
      check("R12 store judged on old reservation", r, 2'b10);
      st("R12 new reservation survives", 32'h0000_A000, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_basic();
      t_mismatch();
      t_granule();
      t_snoop_other();
      t_replace();
      t_same_cycle_snoop();
      t_ld_st_same();
      done = 1'b1;
   end

   initial begin : watchdog
      fork
         begin wait (done); end
         begin
            repeat (5000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule